// File: doc/BRIEF.md
# Oscillator Wake-Up Delay Timer

This block keeps the CPU clock gated after a reset and after a wake from power-down until the selected oscillator has had time to settle. It runs on the oscillator clock and waits in two parts. First it counts a number of oscillator cycles, and that number depends on the kind of source in use. Then it waits a fixed time interval, measured by counting pulses on a reference tick. When both parts are done it raises `clk_ready`, a registered level that the clock gate uses to release the CPU clock.

The clock-source code is sampled at the moment the sequence starts. Crystal sources (low, medium, high range) need the long cycle count. The internal RC oscillator, the watchdog oscillator and an external clock need the short one. With a 1 MHz reference tick, the default of 80 ticks gives a fixed interval of 79 to 80 µs, inside the required 60 to 100 µs window.

The controller has four states. ST_CYCLES counts oscillator cycles. ST_SETTLE counts reference ticks. ST_RUN holds the clock released. ST_SLEEP holds the clock gated during power-down. The transitions are:
- Reset leads to ST_CYCLES.
- ST_CYCLES goes to ST_SETTLE when the cycle count completes.
- ST_SETTLE goes to ST_RUN when the last tick is counted.
- From ST_SLEEP, ST_CYCLES or ST_SETTLE, a wake request leads to ST_CYCLES. This is a restart.
- From any state, a sleep request leads to ST_SLEEP. A restart in the same cycle takes priority over it.

Top module: `osc_wake_timer`

## Requirements
- R1: While `rst_n` is low (sampled on the clock), `clk_ready` is 0. After release, the cycle phase starts at once, so `clk_ready` rises on the clock edge that ends the cycle phase plus the tick phase, counted from the first edge with `rst_n` high.
- R2: For `src_sel` codes 3'b001, 3'b010 and 3'b011 (crystal low, medium, high) and the reserved codes 3'b110 and 3'b111, the cycle phase lasts `XTAL_CYCLES` (default 992) oscillator cycles.
- R3: For `src_sel` codes 3'b000 (external clock), 3'b100 (internal RC) and 3'b101 (watchdog oscillator), the cycle phase lasts `FAST_CYCLES` (default 224) oscillator cycles.
- R4: After the cycle phase, `clk_ready` rises on the edge at which the `SETTLE_TICKS`-th high `ref_tick` is sampled. Ticks sampled during the cycle phase do not count. With `ref_tick` held high, the total time from a restart edge to the rise is the cycle count + 1 + `SETTLE_TICKS` edges.
- R5: Once high, `clk_ready` stays high until a reset or a sleep request. A wake request while it is high has no effect.
- R6: A wake request during the cycle phase, the tick phase or sleep restarts the whole sequence from the cycle phase. It samples `src_sel` anew, and `clk_ready` stays low until the new sequence ends.
- R7: A sleep request drops `clk_ready` on the next edge and keeps it low until a wake request. A wake and a sleep request in the same cycle act as a wake.
- R8: Changes of `src_sel` after it has been sampled at a restart or at reset do not alter the running cycle count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low; starts a wake-up sequence |
| wake_req | input | 1 | Wake request from power-down; restarts a running sequence |
| sleep_req | input | 1 | Power-down entry; gates the clock |
| src_sel | input | 3 | Clock-source code (see R2, R3) |
| ref_tick | input | 1 | One-cycle pulse per reference time unit |
| clk_ready | output | 1 | Registered CPU clock enable |

## Verification
Some properties are checked on every cycle. `clk_ready` never falls without a sleep request. It rises only out of the tick phase on a sampled tick. The cycle counter stays below the decoded limit. A restart always lands in the cycle phase with the counter at zero. The gate is closed in sleep. The exact lengths for each source code, the sampling of the source at restart, and the restarts in the middle of a phase are shown only by the bench scenarios. These compare the output against a behavioural model on every clock and also time whole sequences.

// File: rtl/wake_timer_pkg.sv
package wake_timer_pkg;
    typedef enum logic [1:0] {
        ST_SLEEP  = 2'd0,
        ST_CYCLES = 2'd1,
        ST_SETTLE = 2'd2,
        ST_RUN    = 2'd3
    } wake_state_e;

    localparam logic [2:0] SRC_EXTERNAL = 3'b000;
    localparam logic [2:0] SRC_XTAL_LO  = 3'b001;
    localparam logic [2:0] SRC_XTAL_MID = 3'b010;
    localparam logic [2:0] SRC_XTAL_HI  = 3'b011;
    localparam logic [2:0] SRC_RC       = 3'b100;
    localparam logic [2:0] SRC_WDOG     = 3'b101;
endpackage

// File: rtl/wake_src_decode.sv
module wake_src_decode #(
    parameter int XTAL_CYCLES = 992,
    parameter int FAST_CYCLES = 224,
    parameter int CYC_W       = 10
) (
    input  logic [2:0]       src_code,
    output logic [CYC_W-1:0] cyc_limit
);
    import wake_timer_pkg::*;

    // Fast-starting sources get the short count; crystals and reserved codes the long one.
    always_comb begin
        unique case (src_code)
            SRC_EXTERNAL, SRC_RC, SRC_WDOG: cyc_limit = CYC_W'(FAST_CYCLES);
            default:                        cyc_limit = CYC_W'(XTAL_CYCLES);
        endcase
    end
endmodule

// File: rtl/wake_counter.sv
module wake_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/osc_wake_timer.sv
module osc_wake_timer #(
    parameter int XTAL_CYCLES  = 992,
    parameter int FAST_CYCLES  = 224,
    parameter int SETTLE_TICKS = 80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake_req,
    input  logic       sleep_req,
    input  logic [2:0] src_sel,
    input  logic       ref_tick,
    output logic       clk_ready
);
    import wake_timer_pkg::*;

    localparam int MAX_CYCLES = (XTAL_CYCLES > FAST_CYCLES) ? XTAL_CYCLES : FAST_CYCLES;
    localparam int CYC_W      = $clog2(MAX_CYCLES + 1);
    localparam int TICK_W     = $clog2(SETTLE_TICKS + 1);

    wake_state_e       state, state_nx;
    logic [2:0]        src_q;
    logic [CYC_W-1:0]  cyc_limit;
    logic [CYC_W-1:0]  cyc_cnt;
    logic [TICK_W-1:0] tick_cnt;
    logic              restart;
    logic              cyc_done;
    logic              settle_done;

    assign restart     = wake_req && (state != ST_RUN);
    assign cyc_done    = (state == ST_CYCLES) && (cyc_cnt == cyc_limit - 1'b1);
    assign settle_done = (state == ST_SETTLE) && ref_tick &&
                         (tick_cnt == TICK_W'(SETTLE_TICKS - 1));

    // Source code is captured only when a sequence starts.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            src_q <= src_sel;
        end
    end

    wake_src_decode #(
        .XTAL_CYCLES(XTAL_CYCLES),
        .FAST_CYCLES(FAST_CYCLES),
        .CYC_W      (CYC_W)
    ) u_decode (
        .src_code (src_q),
        .cyc_limit(cyc_limit)
    );

    wake_counter #(.W(CYC_W)) u_cyc_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (restart || (state != ST_CYCLES) || cyc_done),
        .inc  (state == ST_CYCLES),
        .cnt  (cyc_cnt)
    );

    wake_counter #(.W(TICK_W)) u_tick_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  ((state != ST_SETTLE) || settle_done),
        .inc  (ref_tick),
        .cnt  (tick_cnt)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (restart) begin
            state_nx = ST_CYCLES;
        end else if (sleep_req) begin
            state_nx = ST_SLEEP;
        end else begin
            unique case (state)
                ST_SLEEP:  state_nx = ST_SLEEP;
                ST_CYCLES: if (cyc_done)    state_nx = ST_SETTLE;
                ST_SETTLE: if (settle_done) state_nx = ST_RUN;
                ST_RUN:    state_nx = ST_RUN;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_CYCLES;
        end else begin
            state <= state_nx;
        end
    end

    // Output register: the enable follows the state being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_ready <= 1'b0;
        end else begin
            clk_ready <= (state_nx == ST_RUN);
        end
    end

    // R5
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_ready && !sleep_req) |=> clk_ready);

    // R4
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_ready) |-> $past(state == ST_SETTLE && ref_tick));

    // R2 R3
    cyc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CYCLES) |-> (cyc_cnt < cyc_limit));

    // R6
    wake_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && state != ST_RUN) |=> (state == ST_CYCLES && cyc_cnt == '0 && !clk_ready));

    // R7
    sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP) |-> !clk_ready);
endmodule

// File: tb/osc_wake_timer_bench.sv
`timescale 1ns/1ps
module osc_wake_timer_bench;
    localparam int XTAL_N = 992;
    localparam int FAST_N = 224;
    localparam int TICKS  = 80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wake_req = 1'b0;
    logic       sleep_req = 1'b0;
    logic [2:0] src_sel = 3'b001;
    logic       ref_tick = 1'b0;
    logic       clk_ready;

    always #2.5 clk = ~clk;

    osc_wake_timer #(
        .XTAL_CYCLES (XTAL_N),
        .FAST_CYCLES (FAST_N),
        .SETTLE_TICKS(TICKS)
    ) u_osc_wake_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wake_req (wake_req),
        .sleep_req(sleep_req),
        .src_sel  (src_sel),
        .ref_tick (ref_tick),
        .clk_ready(clk_ready)
    );

    int    compared = 0;
    int    mismatched = 0;
    bit    finished = 0;
    bit    tick_always = 0;
    int    tick_div = 0;
    string cur_req = "R1";

    // Reference tick: one pulse in five cycles, or held high.
    always @(negedge clk) begin
        tick_div = (tick_div + 1) % 5;
        ref_tick = tick_always ? 1'b1 : (tick_div == 0);
    end

    function automatic int lim_of(logic [2:0] c);
        case (c)
            3'b000, 3'b100, 3'b101: return FAST_N;
            default:                return XTAL_N;
        endcase
    endfunction

    // Behavioural model: mode 0 sleep, 1 cycles, 2 ticks, 3 released
    int   m_mode = 1;
    int   m_cyc = 0;
    int   m_tick = 0;
    logic exp_ready = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 1; m_cyc = lim_of(src_sel); exp_ready = 1'b0;
        end else if (wake_req && m_mode != 3) begin
            m_mode = 1; m_cyc = lim_of(src_sel); exp_ready = 1'b0;
        end else if (sleep_req) begin
            m_mode = 0; exp_ready = 1'b0;
        end else if (m_mode == 1) begin
            m_cyc--;
            if (m_cyc == 0) begin m_mode = 2; m_tick = TICKS; end
        end else if (m_mode == 2 && ref_tick) begin
            m_tick--;
            if (m_tick == 0) begin m_mode = 3; exp_ready = 1'b1; end
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            compared++;
            if (clk_ready !== exp_ready) begin
                mismatched++;
                $display("FAIL %s per-cycle: clk_ready=%b expected=%b at %0t",
                         cur_req, clk_ready, exp_ready, $time);
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic go_sleep();
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
    endtask

    // Wake, optionally switch the source code right after, and time the rise.
    task automatic timed_wake(input logic [2:0] code, input string req, input bit with_sleep,
                              input bit do_switch, input logic [2:0] new_code);
        int n;
        @(negedge clk);
        cur_req = req;
        src_sel = code; wake_req = 1'b1; sleep_req = with_sleep;
        @(negedge clk);
        wake_req = 1'b0; sleep_req = 1'b0;
        if (do_switch) src_sel = new_code;
        n = 1;
        while (!clk_ready && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(n == lim_of(code) + 1 + TICKS, req, "wake-to-ready edges", n, lim_of(code) + 1 + TICKS);
    endtask

    initial begin
        int n;
        // R1: reset holds the gate closed
        repeat (3) @(negedge clk);
        check(clk_ready == 1'b0, "R1", "ready during reset", clk_ready, 0);
        tick_always = 1'b1;
        rst_n = 1'b1;
        n = 0;
        while (!clk_ready && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(n == XTAL_N + TICKS, "R1", "release-to-ready edges", n, XTAL_N + TICKS);

        // R5: wake while released is ignored
        cur_req = "R5";
        @(negedge clk); wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
        repeat (3) @(negedge clk);
        check(clk_ready == 1'b1, "R5", "ready after ignored wake", clk_ready, 1);

        // R7: sleep gates and holds
        cur_req = "R7";
        go_sleep();
        check(clk_ready == 1'b0, "R7", "ready after sleep", clk_ready, 0);
        repeat (20) @(negedge clk);
        check(clk_ready == 1'b0, "R7", "ready held in sleep", clk_ready, 0);
        timed_wake(3'b100, "R7", 1'b1, 1'b0, 3'b000);

        // R2 / R3: every source code, ticks held high (R4)
        for (int c = 0; c < 8; c++) begin
            go_sleep();
            timed_wake(3'(c), (c == 0 || c == 4 || c == 5) ? "R3" : "R2", 1'b0, 1'b0, 3'b000);
        end

        // R4: pulsed ticks, compared against the model on every cycle
        tick_always = 1'b0;
        cur_req = "R4";
        go_sleep();
        @(negedge clk); src_sel = 3'b101; wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
        repeat (FAST_N + 5 * TICKS + 20) @(negedge clk);
        check(clk_ready == 1'b1, "R4", "ready after pulsed ticks", clk_ready, 1);
        tick_always = 1'b1;

        // R6: restart in the cycle phase
        go_sleep();
        @(negedge clk); cur_req = "R6"; src_sel = 3'b101; wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
        repeat (100) @(negedge clk);
        timed_wake(3'b001, "R6", 1'b0, 1'b0, 3'b000);

        // R6: restart in the tick phase
        go_sleep();
        @(negedge clk); src_sel = 3'b000; wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
        repeat (FAST_N + 30) @(negedge clk);
        check(clk_ready == 1'b0, "R6", "ready low mid-settle", clk_ready, 0);
        timed_wake(3'b100, "R6", 1'b0, 1'b0, 3'b000);

        // R8: source change after sampling has no effect
        go_sleep();
        timed_wake(3'b000, "R8", 1'b0, 1'b1, 3'b011);

        // R1: reset while released
        cur_req = "R1";
        @(negedge clk); rst_n = 1'b0; src_sel = 3'b100;
        @(negedge clk);
        check(clk_ready == 1'b0, "R1", "ready after mid-run reset", clk_ready, 0);
        rst_n = 1'b1;
        n = 0;
        while (!clk_ready && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(n == FAST_N + TICKS, "R1", "second release-to-ready edges", n, FAST_N + TICKS);

        repeat (5) @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !finished) begin
            finished = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual=%0d cycles expected=done", wd);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule